// File: doc/BRIEF.md
# Single-Level Shadow Register Save

This block keeps a one-deep, software-invisible copy of three core registers: the status register, the working register and the bank-select register. Whenever the core takes an interrupt vector, or executes a call flagged as fast, the block records the live values of all three registers at the clock edge. No read or write path to this copy exists; the only way to get at it is a fast return.

When the core executes a return-from-interrupt or a return flagged as fast, it pulses the fast-return strobe. One clock later the block presents the saved values on its restore outputs, together with a one-cycle restore-valid pulse on which the core loads its registers. The restore outputs keep their value between restores.

Only one copy exists. A later capture replaces the earlier one, so a nested interrupt destroys what the outer one saved. When a capture and a restore arrive in the same cycle, the restore delivers the copy as it stood before that edge, and the new capture is stored at the same edge.

Top module: `ctx_shadow_save`

## Requirements
- R1: After reset the restore outputs are zero, restore-valid is low, and a fast return issued before any capture restores zeros.
- R2: A vector strobe stores the live status, working and bank values present at that clock edge.
- R3: A fast-call strobe stores the live values in the same way as a vector strobe.
- R4: A fast-return strobe in cycle N drives the stored values on the restore outputs and restore-valid high in cycle N+1. Restore-valid is low in any cycle that does not follow a fast-return strobe.
- R5: The restore outputs hold their value in every cycle that does not follow a fast-return strobe.
- R6: The store is one level deep. A second capture before a fast return replaces the first, and the first values can no longer be recovered.
- R7: When a capture strobe and a fast-return strobe arrive in the same cycle, the restore delivers the values stored before that edge, and the new live values are stored at that edge.
- R8: Changes on the live register inputs while no capture strobe is active do not alter the stored copy.
- R9: A vector strobe and a fast-call strobe in the same cycle make one capture of the live values.
- R10: A fast return does not empty the store. Fast returns on consecutive cycles each deliver the same values, and restore-valid stays high on each following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| stat_live | input | STAT_W | Live status register value |
| work_live | input | WORK_W | Live working register value |
| bank_live | input | BANK_W | Live bank-select register value |
| vec_stb | input | 1 | Interrupt vector event; captures the live values |
| fcall_stb | input | 1 | Fast call; captures the live values |
| fret_stb | input | 1 | Fast return from interrupt or subroutine; requests a restore |
| stat_rest | output | STAT_W | Restored status value |
| work_rest | output | WORK_W | Restored working value |
| bank_rest | output | BANK_W | Restored bank-select value |
| rest_vld | output | 1 | One-cycle pulse marking the restore values |

## Verification
Captures are driven from the vector strobe, the fast-call strobe and both together. Each one uses distinct field values, so the test can tell whether the right edge was sampled and whether any field was swapped or dropped. Live inputs are scrambled between the capture and the restore, which separates a true stored copy from a design that passes the inputs straight through. Two captures before a single return check the overwrite. A capture in the same cycle as a return, and back-to-back returns, show whether the restore reads the old copy and whether a return wrongly clears the store.

// File: rtl/ctx_shadow_pkg.sv
package ctx_shadow_pkg;
  typedef enum logic [1:0] {
    CAP_NONE   = 2'd0,
    CAP_VECTOR = 2'd1,
    CAP_FCALL  = 2'd2,
    CAP_BOTH   = 2'd3
  } cap_src_e;
endpackage

// File: rtl/ctx_capture_ctrl.sv
module ctx_capture_ctrl
  import ctx_shadow_pkg::*;
(
  input  logic     vec_stb,
  input  logic     fcall_stb,
  input  logic     fret_stb,
  output cap_src_e cap_src,
  output logic     rest_en
);
  always_comb begin
    unique case ({fcall_stb, vec_stb})
      2'b01:   cap_src = CAP_VECTOR;
      2'b10:   cap_src = CAP_FCALL;
      2'b11:   cap_src = CAP_BOTH;
      default: cap_src = CAP_NONE;
    endcase
    rest_en = fret_stb;
  end
endmodule

// File: rtl/ctx_shadow_slot.sv
module ctx_shadow_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [W-1:0] live_d,
  output logic [W-1:0] held_q
);
  logic [W-1:0] held_nxt;

  always_comb begin
    held_nxt = held_q;
    if (cap_en) held_nxt = live_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_nxt;
  end
endmodule

// File: rtl/ctx_restore_out.sv
module ctx_restore_out #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [W-1:0] src_d,
  output logic [W-1:0] out_q,
  output logic         vld_q
);
  logic [W-1:0] out_nxt;
  logic         vld_nxt;

  always_comb begin
    out_nxt = out_q;
    vld_nxt = ld_en;
    if (ld_en) out_nxt = src_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      out_q <= out_nxt;
      vld_q <= vld_nxt;
    end
  end
endmodule

// File: rtl/ctx_shadow_save.sv
module ctx_shadow_save
  import ctx_shadow_pkg::*;
#(
  parameter int STAT_W = 8,
  parameter int WORK_W = 8,
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat_live,
  input  logic [WORK_W-1:0] work_live,
  input  logic [BANK_W-1:0] bank_live,
  input  logic              vec_stb,
  input  logic              fcall_stb,
  input  logic              fret_stb,
  output logic [STAT_W-1:0] stat_rest,
  output logic [WORK_W-1:0] work_rest,
  output logic [BANK_W-1:0] bank_rest,
  output logic              rest_vld
);
  localparam int NUM_F = 3;
  localparam int TOT_W = STAT_W + WORK_W + BANK_W;
  localparam int FLD_W  [NUM_F] = '{BANK_W, WORK_W, STAT_W};
  localparam int FLD_LO [NUM_F] = '{0, BANK_W, BANK_W + WORK_W};

  cap_src_e         cap_src;
  logic             cap_en;
  logic             rest_en;
  logic [TOT_W-1:0] live_vec;
  logic [TOT_W-1:0] shadow_q;
  logic [TOT_W-1:0] rest_vec;

  assign live_vec = {stat_live, work_live, bank_live};
  assign cap_en   = (cap_src != CAP_NONE);

  ctx_capture_ctrl ctrl_i (
    .vec_stb   (vec_stb),
    .fcall_stb (fcall_stb),
    .fret_stb  (fret_stb),
    .cap_src   (cap_src),
    .rest_en   (rest_en)
  );

  for (genvar gi = 0; gi < NUM_F; gi++) begin : g_slot
    ctx_shadow_slot #(.W(FLD_W[gi])) slot_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_en (cap_en),
      .live_d (live_vec[FLD_LO[gi] +: FLD_W[gi]]),
      .held_q (shadow_q[FLD_LO[gi] +: FLD_W[gi]])
    );
  end

  ctx_restore_out #(.W(TOT_W)) rout_i (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_en (rest_en),
    .src_d (shadow_q),
    .out_q (rest_vec),
    .vld_q (rest_vld)
  );

  assign {stat_rest, work_rest, bank_rest} = rest_vec;
endmodule

// File: rtl/ctx_shadow_save_chk.sv
module ctx_shadow_save_chk #(
  parameter int TOT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vec_stb,
  input logic             fcall_stb,
  input logic             fret_stb,
  input logic [TOT_W-1:0] live_vec,
  input logic [TOT_W-1:0] shadow_q,
  input logic [TOT_W-1:0] rest_vec,
  input logic             rest_vld
);
  // R1: first cycle out of reset shows cleared outputs
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!rest_vld && rest_vec == '0));

  // R2 / R3 / R9: any capture strobe stores the live values
  a_r2_capture_stores: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_stb || fcall_stb) |=> shadow_q == $past(live_vec));

  // R8: no capture strobe, store unchanged
  a_r8_store_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_stb || fcall_stb) |=> $stable(shadow_q));

  // R4: valid follows the return strobe
  a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    fret_stb |=> rest_vld);

  // R4: no spurious valid
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !fret_stb |=> !rest_vld);

  // R5: outputs held when no restore
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fret_stb |=> $stable(rest_vec));

  // R7: restore delivers the copy held before the edge
  a_r7_old_copy: assert property (@(posedge clk) disable iff (!rst_n)
    fret_stb |=> rest_vec == $past(shadow_q));
endmodule

bind ctx_shadow_save ctx_shadow_save_chk #(.TOT_W(TOT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .vec_stb   (vec_stb),
  .fcall_stb (fcall_stb),
  .fret_stb  (fret_stb),
  .live_vec  (live_vec),
  .shadow_q  (shadow_q),
  .rest_vec  (rest_vec),
  .rest_vld  (rest_vld)
);

// File: tb/ctx_shadow_save_tb_top.sv
module ctx_shadow_save_tb_top;
  localparam int STAT_W = 8;
  localparam int WORK_W = 8;
  localparam int BANK_W = 4;
  localparam int TOT_W  = STAT_W + WORK_W + BANK_W;

  logic              clk;
  logic              rst_n;
  logic [STAT_W-1:0] stat_live;
  logic [WORK_W-1:0] work_live;
  logic [BANK_W-1:0] bank_live;
  logic              vec_stb, fcall_stb, fret_stb;
  logic [STAT_W-1:0] stat_rest;
  logic [WORK_W-1:0] work_rest;
  logic [BANK_W-1:0] bank_rest;
  logic              rest_vld;

  int checks = 0;
  int errors = 0;

  ctx_shadow_save #(.STAT_W(STAT_W), .WORK_W(WORK_W), .BANK_W(BANK_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .stat_live(stat_live), .work_live(work_live), .bank_live(bank_live),
    .vec_stb(vec_stb), .fcall_stb(fcall_stb), .fret_stb(fret_stb),
    .stat_rest(stat_rest), .work_rest(work_rest), .bank_rest(bank_rest),
    .rest_vld(rest_vld)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [TOT_W-1:0] outs();
    return {stat_rest, work_rest, bank_rest};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic scramble();
    stat_live = $urandom; work_live = $urandom; bank_live = $urandom;
  endtask

  // drive a capture at one edge, then clear strobes and scramble live inputs
  task automatic capture(input bit v, input bit f, input logic [TOT_W-1:0] val);
    @(negedge clk);
    {stat_live, work_live, bank_live} = val;
    vec_stb = v; fcall_stb = f;
    @(negedge clk);
    vec_stb = 1'b0; fcall_stb = 1'b0;
    scramble();
  endtask

  // issue one fast return; check the valid pulse, the values, and the hold afterwards
  task automatic restore_check(input logic [TOT_W-1:0] exp, input string req);
    @(negedge clk);
    fret_stb = 1'b1;
    @(negedge clk);
    fret_stb = 1'b0;
    chk(rest_vld == 1'b1, {req, " R4 valid"}, 32'(rest_vld), 32'd1);
    chk(outs() == exp, req, 32'(outs()), 32'(exp));
    scramble();
    @(negedge clk);
    chk(rest_vld == 1'b0, {req, " R4 pulse end"}, 32'(rest_vld), 32'd0);
    chk(outs() == exp, {req, " R5 hold"}, 32'(outs()), 32'(exp));
  endtask

  task automatic t_reset();
    chk(rest_vld == 1'b0, "R1 valid", 32'(rest_vld), 32'd0);
    chk(outs() == '0, "R1 outputs", 32'(outs()), 32'd0);
    restore_check('0, "R1 restore zeros");
  endtask

  task automatic t_vector();
    capture(1'b1, 1'b0, 20'hA5_3C_7);
    repeat (3) begin @(negedge clk); scramble(); end
    chk(outs() == '0 && !rest_vld, "R5 no change before return", 32'(outs()), 32'd0);
    restore_check(20'hA5_3C_7, "R2 vector capture R8");
  endtask

  task automatic t_fcall();
    capture(1'b0, 1'b1, 20'h1E_F0_9);
    restore_check(20'h1E_F0_9, "R3 fast call capture");
  endtask

  task automatic t_both();
    capture(1'b1, 1'b1, 20'h66_81_2);
    restore_check(20'h66_81_2, "R9 both strobes");
  endtask

  task automatic t_overwrite();
    capture(1'b1, 1'b0, 20'h11_22_3);
    capture(1'b1, 1'b0, 20'hC4_D5_E);
    restore_check(20'hC4_D5_E, "R6 overwrite");
  endtask

  task automatic t_same_cycle();
    capture(1'b0, 1'b1, 20'h0F_0F_5);
    @(negedge clk);
    {stat_live, work_live, bank_live} = 20'h9A_BC_D;
    vec_stb = 1'b1; fret_stb = 1'b1;
    @(negedge clk);
    vec_stb = 1'b0; fret_stb = 1'b0;
    scramble();
    chk(rest_vld == 1'b1, "R7 valid", 32'(rest_vld), 32'd1);
    chk(outs() == 20'h0F_0F_5, "R7 old copy", 32'(outs()), 32'h0F0F5);
    restore_check(20'h9A_BC_D, "R7 new stored");
  endtask

  task automatic t_back_to_back();
    capture(1'b1, 1'b0, 20'h3B_47_8);
    @(negedge clk); fret_stb = 1'b1;
    @(negedge clk);
    chk(rest_vld && outs() == 20'h3B_47_8, "R10 first", 32'(outs()), 32'h3B478);
    @(negedge clk); fret_stb = 1'b0;
    chk(rest_vld && outs() == 20'h3B_47_8, "R10 second", 32'(outs()), 32'h3B478);
    @(negedge clk);
    chk(!rest_vld, "R10 pulse end", 32'(rest_vld), 32'd0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    vec_stb = 1'b0; fcall_stb = 1'b0; fret_stb = 1'b0;
    stat_live = '0; work_live = '0; bank_live = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_vector();
    t_fcall();
    t_both();
    t_overwrite();
    t_same_cycle();
    t_back_to_back();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule